// File: doc/BRIEF.md
# Oversampled Serial Receiver with Buffered Status

This block recovers characters from an asynchronous serial line. A clock enable arriving at sixteen times the bit rate paces a small state machine. The machine finds a falling edge and confirms the start bit by a three-sample vote around the middle of the bit. It then collects eight or nine data bits, least significant bit first, and judges the stop bit the same way. A finished character moves into a single holding register. The host reads that register through `data_o` and `bit8_o` and acknowledges it with a one-cycle `rd_i` strobe.

A status byte reports three flags: receive complete, framing error and overrun. Overrun is buffered. When a new character finishes while the holding register is still unread, that character is dropped and the overrun is only noted. The flag appears when the host reads the older character, so the host learns that something was lost right after the character it just took. Lowering `rx_en_i` stops the receiver and freezes the flags in their current state. An interrupt request follows the receive complete flag when `irq_en_i` is set.

Top module: `serial_rx_buffered`

## Requirements
- R1: In eight-bit mode (`nine_bit_i`=0), a frame of one low start bit, eight data bits sent least significant bit first, and a stop bit loads the data into `data_o` and sets receive complete, which is `status_o[7]`.
- R2: With `nine_bit_i`=1, nine data bits are received and the ninth appears on `bit8_o`. In eight-bit mode `bit8_o` reads 0.
- R3: The framing error flag, `status_o[4]`, is set when the stop bit of the transferred character samples low and cleared when it samples high.
- R4: A one-cycle `rd_i` pulse clears receive complete.
- R5: A character that completes while receive complete is still set is discarded. `data_o`, `bit8_o` and the framing error flag keep the older character, and the overrun flag, `status_o[3]`, stays 0 until that older character is read.
- R6: The read that removes the older character sets the overrun flag.
- R7: The next character that is transferred without an overrun clears the overrun flag.
- R8: While `rx_en_i` is 0, frames on the line set no flag and leave `data_o` unchanged.
- R9: Clearing `rx_en_i` leaves the framing error and overrun flags and receive complete exactly as they were. Only a read still clears receive complete.
- R10: `irq_o` is 1 exactly when `irq_en_i` is 1 and receive complete is set.
- R11: Status bits 6, 5, 2, 1 and 0 always read 0.
- R12: A low pulse that has ended before the start bit's middle samples counts as a false start. It produces no character, and the receiver goes back to waiting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Clock enable at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| nine_bit_i | input | 1 | Select nine data bits per character |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | One-cycle read strobe for the holding register |
| data_o | output | DATA_W | Holding register, low data bits |
| bit8_o | output | 1 | Ninth received bit |
| status_o | output | 8 | {rx complete, 0, 0, framing error, overrun, 0, 0, 0} |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A wrong sampling phase or a wrong bit count shows up within one frame. The character is shifted or truncated in `data_o`, or the stop vote lands on a data bit and the framing error flag takes the wrong value. If the pending overrun marker is lost or raised early, the port shows it at the next read: the overrun bit either fails to rise there or is already set beforehand. A receiver that keeps running while disabled shows up one frame later, as a changed `data_o` or a flag that was raised.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= 1'b1;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              nine_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o,
  output logic              stop_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] S_LO  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] S_MID = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] S_HI  = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OVS - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W:0]   sh_q;
  logic [1:0]        vote_q;
  logic              done_q, stop_q;
  logic              maj;
  logic [IDX_W-1:0]  last_idx;

  assign maj      = maj3(vote_q[0], vote_q[1], rx_i);
  assign last_idx = nine_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      vote_q  <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        if (state_q == RX_IDLE) begin
          if (!rx_i) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == S_LO)  vote_q[0] <= rx_i;
          if (cnt_q == S_MID) vote_q[1] <= rx_i;
          if (cnt_q == S_HI) begin
            unique case (state_q)
              RX_START: if (maj) state_q <= RX_IDLE;  // false start
              RX_DATA:  sh_q[idx_q] <= maj;
              RX_STOP: begin
                stop_q  <= maj;
                done_q  <= 1'b1;
                state_q <= RX_IDLE;  // finish mid stop bit to catch the next edge
              end
              default: ;
            endcase
          end
          if (cnt_q == S_END) begin
            cnt_q <= '0;
            if (state_q == RX_START) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
              sh_q    <= '0;
            end else if (state_q == RX_DATA) begin
              if (idx_q == last_idx) state_q <= RX_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q[DATA_W-1:0];
  assign bit8_o = nine_i & sh_q[DATA_W];
  assign stop_o = stop_q;
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit8_i,
  input  logic              stop_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o,
  output logic              full_o,
  output logic              fe_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q;
  logic bit8_q, full_q, fe_q, ovr_q, pend_q;
  logic take, drop;

  // a read in the same cycle frees the register for the new character
  assign take = done_i & en_i & (~full_q | rd_i);
  assign drop = done_i & en_i & full_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      bit8_q <= 1'b0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (take) begin
      data_q <= data_i;
      bit8_q <= bit8_i;
      full_q <= 1'b1;
      fe_q   <= ~stop_i;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (rd_i) full_q <= 1'b0;
      if (rd_i && en_i && pend_q) begin
        ovr_q  <= 1'b1;
        pend_q <= 1'b0;
      end
      if (drop) pend_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign bit8_o = bit8_q;
  assign full_o = full_q;
  assign fe_o   = fe_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/serial_rx_buffered.sv
module serial_rx_buffered #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o,
  output logic [7:0]        status_o,
  output logic              irq_o
);
  logic rx_s;
  logic frame_done, frame_b8, frame_stop;
  logic [DATA_W-1:0] frame_data;
  logic full, fe, ovr;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  serial_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .tick_i(tick16_i),
    .rx_i  (rx_s),
    .nine_i(nine_bit_i),
    .done_o(frame_done),
    .data_o(frame_data),
    .bit8_o(frame_b8),
    .stop_o(frame_stop)
  );

  serial_rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .done_i(frame_done),
    .data_i(frame_data),
    .bit8_i(frame_b8),
    .stop_i(frame_stop),
    .rd_i  (rd_i),
    .data_o(data_o),
    .bit8_o(bit8_o),
    .full_o(full),
    .fe_o  (fe),
    .ovr_o (ovr)
  );

  assign status_o = {full, 2'b00, fe, ovr, 3'b000};
  assign irq_o    = irq_en_i & full;
endmodule

// File: rtl/serial_rx_buffered_chk.sv
module serial_rx_buffered_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic              irq_en_i,
  input logic              irq_o,
  input logic [7:0]        status_o,
  input logic [DATA_W-1:0] data_o,
  input logic              frame_done
);
  // R4
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) && !$past(frame_done) |-> !status_o[7]);

  // R5
  drop_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_done && status_o[7] && !rd_i) |-> data_o == $past(data_o));

  // R6
  ovr_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(rd_i));

  // R8
  no_set_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_en_i) && !$past(status_o[7]) |-> !status_o[7]);

  // R9
  frozen_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_en_i) |-> status_o[4:3] == $past(status_o[4:3]));

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i && status_o[7]);
endmodule

bind serial_rx_buffered serial_rx_buffered_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_serial_rx_buffered.sv
module test_serial_rx_buffered;
  localparam int TDIV = 3;
  localparam int BITC = 16 * TDIV;
  // [10]=nine-bit mode, [9]=ninth bit, [8]=stop bit level, [7:0]=data
  localparam logic [10:0] VEC [7] = '{11'h155, 11'h7A3, 11'h000, 11'h5FF,
                                      11'h181, 11'h63C, 11'h3C3};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic rx_en = 1'b1, nine = 1'b0, irq_en = 1'b1, rd = 1'b0;
  logic [7:0] data, status;
  logic b8, irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  end

  serial_rx_buffered i_serial_rx_buffered (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx), .rx_en_i(rx_en),
    .nine_bit_i(nine), .irq_en_i(irq_en), .rd_i(rd), .data_o(data),
    .bit8_o(b8), .status_o(status), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic nb, input logic b9, input logic stp);
    hold_line(1'b0, BITC);
    for (int i = 0; i < 8; i++) hold_line(d[i], BITC);
    if (nb) hold_line(b9, BITC);
    hold_line(stp, BITC);
    hold_line(1'b1, 2 * BITC);
  endtask

  task automatic read_hold();
    rd = 1'b1; @(negedge clk);
    rd = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 0);
    chk(data == 8'h00 && !b8, "R2 reset data", data, 0);
    chk(!irq, "R10 reset irq", irq, 0);

    foreach (VEC[k]) begin
      nine = VEC[k][10];
      @(negedge clk);
      send(VEC[k][7:0], VEC[k][10], VEC[k][9], VEC[k][8]);
      chk(data == VEC[k][7:0], "R1 data", data, VEC[k][7:0]);
      chk(status[7], "R1 rx complete", status[7], 1);
      chk(b8 == (VEC[k][10] & VEC[k][9]), "R2 ninth bit", b8, VEC[k][10] & VEC[k][9]);
      chk(status[4] == !VEC[k][8], "R3 framing error", status[4], !VEC[k][8]);
      chk(irq, "R10 irq raised", irq, 1);
      chk((status & 8'h67) == 0, "R11 reserved bits", status, 0);
      read_hold();
      chk(!status[7], "R4 read clears", status[7], 0);
      chk(!irq, "R10 irq drops", irq, 0);
    end

    nine = 1'b0;
    send(8'h11, 1'b0, 1'b0, 1'b1);
    irq_en = 1'b0; @(negedge clk);
    chk(!irq && status[7], "R10 irq disabled", irq, 0);
    irq_en = 1'b1;
    send(8'h22, 1'b0, 1'b0, 1'b0);
    chk(data == 8'h11, "R5 old data kept", data, 8'h11);
    chk(status == 8'h80, "R5 overrun hidden, fe kept", status, 8'h80);
    read_hold();
    chk(status == 8'h08, "R6 overrun after read", status, 8'h08);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    chk(data == 8'h33 && status == 8'h80, "R7 overrun cleared", status, 8'h80);
    read_hold();

    send(8'h44, 1'b0, 1'b0, 1'b0);
    rx_en = 1'b0; @(negedge clk);
    chk(status == 8'h90, "R9 flags kept on disable", status, 8'h90);
    send(8'h55, 1'b0, 1'b0, 1'b1);
    chk(data == 8'h44 && status == 8'h90, "R8 frame ignored", {data, status}, 16'h4490);
    read_hold();
    chk(status == 8'h10, "R9 read while disabled", status, 8'h10);
    send(8'h66, 1'b0, 1'b0, 1'b1);
    chk(status == 8'h10 && data == 8'h44, "R8 no set while disabled", {data, status}, 16'h4410);
    rx_en = 1'b1;
    hold_line(1'b1, BITC);

    hold_line(1'b0, 12);
    hold_line(1'b1, 2 * BITC);
    chk(!status[7], "R12 glitch ignored", status[7], 0);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(data == 8'h5A && status == 8'h80, "R12 idle after false start", {data, status}, 16'h5A80);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule